// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex serial port that moves 8-bit words over a shared bit clock, with no start, stop or parity bits. One register holds the next byte to send and a shift register drives it onto the line. A second shift register collects the incoming bits and hands each finished byte to a receive holding register. The bit clock comes from a programmable divider of the system clock or from an external clock pin. When the external pin is used, the pin is resampled into the system clock domain.

The receiver has no clock of its own. It shifts in on the same clock edges that the transmitter generates, so the host starts a reception by writing a byte, often a dummy byte, to the transmit side. Configuration inputs select the following: clock polarity, bit order, data inversion, gating on a clear-to-send input, when the transmit interrupt fires, and a continuous mode in which each read of the received byte starts the next exchange. A ready-to-receive output tells the far end whether a byte can be accepted.

Top module: `sync_serial_port`

## Requirements
- R1: Each transfer moves exactly 8 data bits and has no framing bits. With `cfg_msb_first`=0 the wire carries data bit 0 first. With `cfg_msb_first`=1 it carries bit 7 first. Both directions use the same order, so a byte looped from `txd` to `rxd` comes back unchanged.
- R2: With `cfg_ext_clk`=0, every phase of `sclk_out` during a transfer lasts `cfg_divisor`+1 system clock cycles. The full bit period is therefore 2×(`cfg_divisor`+1) cycles, for divisors from 0 to 255.
- R3: With `cfg_ext_clk`=1, bits move on edges of `sclk_in` and `sclk_out` stays at its idle level. A transfer only starts while `sclk_in` rests at the idle level.
- R4: A transfer starts only when all three conditions hold: `cfg_tx_en`=1, the transmit register holds an unsent byte, and `cts_n` is low or `cfg_cts_en`=0.
- R5: A byte is received only if `cfg_rx_en`=1 when the transfer starts. With `cfg_tx_en`=0 no exchange happens at all. A transfer sent with `cfg_rx_en`=0 raises no `rx_irq`.
- R6: With `cfg_txirq_done`=0, `tx_irq` pulses for one cycle when the byte moves into the shift register, before any clock edge. With `cfg_txirq_done`=1 it pulses on the 8th sampling edge, when the shift register is done.
- R7: When a byte completes, `rx_irq` pulses for one cycle and `rd_data` shows the byte in that same cycle.
- R8: `overrun` goes high on the 7th received bit if the previous byte is still unread. That frame raises no `rx_irq`. A read (`rd_en`) clears `overrun`.
- R9: With `cfg_cpol`=0 the clock idles high, data changes on the falling edge and is sampled on the rising edge. With `cfg_cpol`=1 the clock idles low and both edges swap roles.
- R10: With `cfg_invert`=1, the bits on `txd` are the complement of the data. The received bits are complemented back, so a constant high `rxd` yields 0x00.
- R11: With `cfg_cont_rx`=1 and both enables set, each read re-sends the last written byte. That re-send receives a new byte with no further write. With `cfg_cont_rx`=0, a read starts nothing.
- R12: `rts_n` is low only while `cfg_rx_en`=1 and no unread byte is held. Otherwise it is high.
- R13: `tx_buf_empty` goes high when the byte moves into the shift register. A second write made during a transfer is kept and sent right after the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_ext_clk | input | 1 | 1 selects the external bit clock |
| cfg_cpol | input | 1 | Clock polarity (0 idles high) |
| cfg_msb_first | input | 1 | Bit order (1 sends bit 7 first) |
| cfg_invert | input | 1 | Invert serial data both directions |
| cfg_cts_en | input | 1 | Gate transmit starts on cts_n |
| cfg_txirq_done | input | 1 | Transmit interrupt at end of shift |
| cfg_cont_rx | input | 1 | Continuous receive mode |
| cfg_divisor | input | 8 | Internal clock divisor n |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe for the received byte |
| rd_data | output | 8 | Last received byte |
| tx_buf_empty | output | 1 | Transmit register free |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| overrun | output | 1 | Overrun flag |
| sclk_in | input | 1 | External bit clock |
| sclk_out | output | 1 | Generated bit clock |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Ready to receive, active low |

## Verification
The bench loops `txd` back to `rxd` and rebuilds every frame from the clock edges it observes. A reversed order in only one direction, a sampling edge on the wrong polarity, or an inversion applied once would each return a mangled byte. Divisor boundaries 0 and 255 are measured as phase lengths, which exposes an off-by-one divider. The overrun case checks the flag after the 6th and after the 7th bit, so a design that flags at frame end or one bit early fails. It also checks that the overrun frame raises no receive interrupt. Further cases block on `cts_n`, a disabled transmitter and a non-idle external clock, and test that continuous mode re-sends on a read and stops once the mode is cleared.

// File: rtl/ssp_pkg.sv
// Package: shared types for the synchronous serial port.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package ssp_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } ssp_state_e;

endpackage

// File: rtl/ssp_clk_gen.sv
// Bit clock source: either divides the system clock so that every phase lasts
// divisor+1 cycles, or resamples an external clock pin. It reports leading
// edges (away from idle, where data is driven) and trailing edges (back to
// idle, where data is sampled). Assumes the external clock is slower than
// about one sixth of clk.
module ssp_clk_gen #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ext_sel,
    input  logic             cpol,
    input  logic [DIV_W-1:0] divisor,
    input  logic             sclk_in,
    output logic             lead_pulse,
    output logic             trail_pulse,
    output logic             sclk_out,
    output logic             ext_at_idle
);
    localparam int SYNC_W = SYNC_STAGES + 1;

    logic             idle_lvl;
    logic [DIV_W-1:0] cnt_q;
    logic             sclk_q;
    logic [SYNC_W-1:0] sync_q;
    logic             ext_now, ext_prev, ext_edge, int_tick;

    assign idle_lvl = ~cpol;

    // Internal divider: toggles the generated clock every divisor+1 cycles while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (!run || ext_sel) begin
            cnt_q  <= '0;
            sclk_q <= idle_lvl;
        end else if (cnt_q == divisor) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // External clock resampler: shifts the pin through a synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_W-2:0], sclk_in};
        end
    end

    assign ext_now  = sync_q[SYNC_STAGES-1];
    assign ext_prev = sync_q[SYNC_STAGES];
    assign ext_edge = run && ext_sel && (ext_now != ext_prev);
    assign int_tick = run && !ext_sel && (cnt_q == divisor);

    assign lead_pulse  = (int_tick && (sclk_q == idle_lvl)) ||
                         (ext_edge && (ext_prev == idle_lvl));
    assign trail_pulse = (int_tick && (sclk_q != idle_lvl)) ||
                         (ext_edge && (ext_now == idle_lvl));
    assign sclk_out    = (run && !ext_sel) ? sclk_q : idle_lvl;
    assign ext_at_idle = (ext_now == idle_lvl) && (ext_prev == idle_lvl);

endmodule

// File: rtl/ssp_tx_path.sv
// Transmit side: a one-byte holding register plus a shift register. A leading
// edge drives the next bit (optionally inverted), a trailing edge advances
// the shifter. Assumes load, lead and trail never coincide.
module ssp_tx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rearm,
    input  logic              load,
    input  logic              lead,
    input  logic              trail,
    input  logic              msb_first,
    input  logic              invert,
    output logic              tx_full,
    output logic              txd
);
    logic [DATA_W-1:0] hold_q, sh_q;

    // Holding register: a write fills it, a load empties it, a rearm refills it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            tx_full <= 1'b0;
        end else begin
            if (load)  tx_full <= 1'b0;
            if (rearm) tx_full <= 1'b1;
            if (wr_en) begin
                hold_q  <= wr_data;
                tx_full <= 1'b1;
            end
        end
    end

    // Shifter: takes the held byte, drives a bit on lead, moves on trail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            txd  <= 1'b1;
        end else if (load) begin
            sh_q <= hold_q;
        end else begin
            if (lead)  txd  <= (msb_first ? sh_q[DATA_W-1] : sh_q[0]) ^ invert;
            if (trail) sh_q <= msb_first ? (sh_q << 1) : (sh_q >> 1);
        end
    end

endmodule

// File: rtl/ssp_rx_path.sv
// Receive side: shifts sampled bits in the selected order. It moves a finished
// byte into the holding register and raises overrun when the seventh bit
// arrives while the held byte is unread. A frame that overran does not update
// the holding register or signal completion.
module ssp_rx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sample,
    input  logic              seventh,
    input  logic              last,
    input  logic              rxd,
    input  logic              rd_en,
    input  logic              msb_first,
    input  logic              invert,
    output logic [DATA_W-1:0] rx_buf,
    output logic              rx_full,
    output logic              overrun,
    output logic              rx_done
);
    logic [DATA_W-1:0] sh_q, sh_nxt;
    logic              bit_in, ovr_frame;

    assign bit_in = rxd ^ invert;
    assign sh_nxt = msb_first ? {sh_q[DATA_W-2:0], bit_in}
                              : {bit_in, sh_q[DATA_W-1:1]};

    // Shifter: captures one bit per sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      sh_q <= '0;
        else if (sample) sh_q <= sh_nxt;
    end

    // Holding register and flags: completion, read and overrun handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf    <= '0;
            rx_full   <= 1'b0;
            overrun   <= 1'b0;
            ovr_frame <= 1'b0;
            rx_done   <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            if (start) ovr_frame <= 1'b0;
            if (rd_en) begin
                rx_full <= 1'b0;
                overrun <= 1'b0;
            end
            if (sample && seventh && rx_full) begin
                overrun   <= 1'b1;
                ovr_frame <= 1'b1;
            end
            if (sample && last && !ovr_frame) begin
                rx_buf  <= sh_nxt;
                rx_full <= 1'b1;
                rx_done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sync_serial_port.sv
// Full-duplex clock-synchronous serial port, 8 bits per word, no framing.
// Sequences one transfer at a time. The receiver only runs inside a transfer
// started by the transmitter. Assumes configuration changes only while idle.
module sync_serial_port #(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tx_en,
    input  logic              cfg_rx_en,
    input  logic              cfg_ext_clk,
    input  logic              cfg_cpol,
    input  logic              cfg_msb_first,
    input  logic              cfg_invert,
    input  logic              cfg_cts_en,
    input  logic              cfg_txirq_done,
    input  logic              cfg_cont_rx,
    input  logic [DIV_W-1:0]  cfg_divisor,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_buf_empty,
    output logic              tx_irq,
    output logic              rx_irq,
    output logic              overrun,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              txd,
    input  logic              rxd,
    input  logic              cts_n,
    output logic              rts_n
);
    import ssp_pkg::*;

    localparam int CNT_W = $clog2(DATA_W);

    ssp_state_e       state_q;
    logic [CNT_W-1:0] bit_cnt;
    logic             rx_act;
    logic [1:0]       cts_sync;
    logic             busy, lead, trail, ext_at_idle, tx_full, rx_full;
    logic             start_ok, last, seventh, rearm;

    assign busy     = (state_q == ST_SHIFT);
    assign start_ok = !busy && cfg_tx_en && tx_full &&
                      (!cfg_cts_en || !cts_sync[1]) &&
                      (!cfg_ext_clk || ext_at_idle);
    assign seventh  = (bit_cnt == CNT_W'(DATA_W - 2));
    assign last     = trail && (bit_cnt == CNT_W'(DATA_W - 1));
    assign rearm    = rd_en && cfg_cont_rx && cfg_rx_en && cfg_tx_en;

    // Clear-to-send resampler.
    always_ff @(posedge clk) begin
        if (!rst_n) cts_sync <= 2'b11;
        else        cts_sync <= {cts_sync[0], cts_n};
    end

    // Transfer sequencer: starts a frame, counts sampling edges, ends after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_cnt <= '0;
            rx_act  <= 1'b0;
        end else if (start_ok) begin
            state_q <= ST_SHIFT;
            bit_cnt <= '0;
            rx_act  <= cfg_rx_en;
        end else if (busy && trail) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (last) state_q <= ST_IDLE;
        end
    end

    // Transmit interrupt: at load or at shift completion, per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_irq <= 1'b0;
        else        tx_irq <= (start_ok && !cfg_txirq_done) || (last && cfg_txirq_done);
    end

    ssp_clk_gen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) clk_gen_i (
        .clk(clk), .rst_n(rst_n), .run(busy), .ext_sel(cfg_ext_clk), .cpol(cfg_cpol),
        .divisor(cfg_divisor), .sclk_in(sclk_in), .lead_pulse(lead),
        .trail_pulse(trail), .sclk_out(sclk_out), .ext_at_idle(ext_at_idle)
    );

    ssp_tx_path #(.DATA_W(DATA_W)) tx_path_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rearm(rearm),
        .load(start_ok), .lead(lead), .trail(trail), .msb_first(cfg_msb_first),
        .invert(cfg_invert), .tx_full(tx_full), .txd(txd)
    );

    ssp_rx_path #(.DATA_W(DATA_W)) rx_path_i (
        .clk(clk), .rst_n(rst_n), .start(start_ok), .sample(trail && rx_act),
        .seventh(seventh), .last(last), .rxd(rxd), .rd_en(rd_en),
        .msb_first(cfg_msb_first), .invert(cfg_invert), .rx_buf(rd_data),
        .rx_full(rx_full), .overrun(overrun), .rx_done(rx_irq)
    );

    assign tx_buf_empty = !tx_full;
    assign rts_n        = !(cfg_rx_en && !rx_full);

endmodule

// File: rtl/ssp_checker.sv
// Checker: temporal properties of the serial port, bound to every instance.
module ssp_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic cfg_tx_en,
    input logic cfg_txirq_done,
    input logic tx_irq,
    input logic rx_irq,
    input logic rx_full,
    input logic overrun,
    input logic rts_n
);
    // R4: a frame only begins when the transmitter was enabled.
    p_start_needs_tx_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cfg_tx_en));

    // R5: a received byte always comes out of an active transfer.
    p_rx_inside_transfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(busy));

    // R6: load-time interrupt coincides with the transfer starting.
    p_txirq_at_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !cfg_txirq_done && $stable(cfg_txirq_done)) |-> busy);

    // R6: completion interrupt arrives once the shifter has stopped.
    p_txirq_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && cfg_txirq_done && $stable(cfg_txirq_done)) |-> !busy);

    // R7: a receive interrupt means a byte is being held.
    p_rxirq_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);

    // R8: overrun can only arise against an unread byte.
    p_overrun_needs_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_full));

    // R8: an overrun frame signals no completion.
    p_overrun_no_rxirq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !rx_irq);

    // R12: a freshly received byte withdraws readiness.
    p_rts_after_rx_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rts_n);

endmodule

bind sync_serial_port ssp_checker chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cfg_tx_en(cfg_tx_en),
    .cfg_txirq_done(cfg_txirq_done), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .rx_full(rx_full), .overrun(overrun), .rts_n(rts_n)
);

// File: tb/sync_serial_port_tb_top.sv
module sync_serial_port_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       cfg_tx_en, cfg_rx_en, cfg_ext_clk, cfg_cpol, cfg_msb_first;
    logic       cfg_invert, cfg_cts_en, cfg_txirq_done, cfg_cont_rx;
    logic [7:0] cfg_divisor;
    logic       wr_en, rd_en, rd_auto, rd_man;
    logic [7:0] wr_data, rd_data;
    logic       tx_buf_empty, tx_irq, rx_irq, overrun;
    logic       sclk_in, sclk_out, txd, rxd, cts_n, rts_n;
    logic       lb_en, ext_rxd;

    assign rxd   = lb_en ? txd : ext_rxd;
    assign rd_en = rd_auto | rd_man;

    sync_serial_port dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
        .cfg_ext_clk(cfg_ext_clk), .cfg_cpol(cfg_cpol), .cfg_msb_first(cfg_msb_first),
        .cfg_invert(cfg_invert), .cfg_cts_en(cfg_cts_en), .cfg_txirq_done(cfg_txirq_done),
        .cfg_cont_rx(cfg_cont_rx), .cfg_divisor(cfg_divisor), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .tx_buf_empty(tx_buf_empty),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .overrun(overrun), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .txd(txd), .rxd(rxd), .cts_n(cts_n), .rts_n(rts_n)
    );

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] rxq[$];
    logic [7:0] txq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] wire_of(input logic [7:0] d, input bit msb, input bit inv);
        logic [7:0] w;
        for (int k = 0; k < 8; k++) w[k] = (msb ? d[7-k] : d[k]) ^ inv;
        return w;
    endfunction

    // Monitor state
    logic       prev_sclk, prev_cpol, trail_now, ovr6, ovr7, txirq_trail;
    logic [7:0] wbits, exp_b;
    int         wcnt, act_len, last_act_len, trails, rx_irqs, tx_irqs, txirq_wcnt;
    bit         auto_read;

    // Monitor: rebuilds frames from sclk_out, pops the scoreboards, auto-reads.
    always @(negedge clk) begin
        rd_auto <= 1'b0;
        if (!rst_n) begin
            prev_sclk = sclk_out; prev_cpol = cfg_cpol;
            wcnt = 0; act_len = 0; last_act_len = 0; trails = 0;
            rx_irqs = 0; tx_irqs = 0; txirq_wcnt = -1; txirq_trail = 1'b0;
            ovr6 = 1'b0; ovr7 = 1'b0; wbits = '0;
        end else begin
            trail_now = (prev_cpol == cfg_cpol) && !cfg_ext_clk &&
                        (prev_sclk == cfg_cpol) && (sclk_out == ~cfg_cpol);
            if (tx_irq) begin
                tx_irqs++; txirq_wcnt = wcnt; txirq_trail = trail_now;
            end
            if (sclk_out != ~cfg_cpol) act_len++;
            if (trail_now) begin
                last_act_len = act_len; act_len = 0;
                wbits[wcnt] = txd; wcnt++; trails++;
                if (wcnt == 6) ovr6 = overrun;
                if (wcnt == 7) ovr7 = overrun;
                if (wcnt == 8) begin
                    wcnt = 0;
                    if (txq.size() > 0) begin
                        exp_b = txq.pop_front();
                        chk(wbits == exp_b, "R1", "wire bit sequence", wbits, exp_b);
                    end
                end
            end
            if (rx_irq) begin
                rx_irqs++;
                if (rxq.size() > 0) begin
                    exp_b = rxq.pop_front();
                    chk(rd_data == exp_b, "R7", "received byte", rd_data, exp_b);
                end else begin
                    chk(1'b0, "R5", "rx_irq with nothing expected", 1, 0);
                end
                if (auto_read) rd_auto <= 1'b1;
            end
            prev_sclk = sclk_out; prev_cpol = cfg_cpol;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic send(input logic [7:0] d, input bit exp_rx, input bit exp_wire);
        if (exp_wire) txq.push_back(wire_of(d, cfg_msb_first, cfg_invert));
        if (exp_rx)   rxq.push_back(cfg_invert && !lb_en ? 8'h00 : d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic wait_frame();
        tick(16 * (int'(cfg_divisor) + 1) + 12);
    endtask

    task automatic host_read();
        @(posedge clk); #2;
        rd_man = 1'b1;
        tick(1);
        rd_man = 1'b0;
    endtask

    task automatic ext_pulses();
        for (int b = 0; b < 8; b++) begin
            sclk_in = cfg_cpol; tick(8);
            sclk_in = ~cfg_cpol; tick(8);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    int base_rx, base_tr, base_tx;

    initial begin
        rst_n = 1'b0; cfg_tx_en = 0; cfg_rx_en = 0; cfg_ext_clk = 0; cfg_cpol = 0;
        cfg_msb_first = 0; cfg_invert = 0; cfg_cts_en = 0; cfg_txirq_done = 0;
        cfg_cont_rx = 0; cfg_divisor = 8'd3; wr_en = 0; wr_data = 0; rd_man = 0;
        sclk_in = 1; cts_n = 1; lb_en = 1; ext_rxd = 0; auto_read = 1;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // Reset state
        chk(!tx_irq && !rx_irq, "R6", "irq idle after reset", {tx_irq, rx_irq}, 0);
        chk(!overrun, "R8", "overrun after reset", overrun, 0);
        chk(tx_buf_empty, "R13", "tx empty after reset", tx_buf_empty, 1);
        chk(rts_n, "R12", "rts_n with receiver off", rts_n, 1);
        chk(sclk_out == 1'b1, "R9", "clock idles high with cpol 0", sclk_out, 1);
        chk(txd == 1'b1, "R1", "txd after reset", txd, 1);

        // Loopback, LSB first, divisor 3
        cfg_tx_en = 1; cfg_rx_en = 1; tick(1);
        chk(!rts_n, "R12", "rts_n low when ready", rts_n, 0);
        send(8'hA5, 1, 1); wait_frame();
        chk(last_act_len == 4, "R2", "phase length divisor 3", last_act_len, 4);
        chk(rx_irqs == 1, "R7", "one byte received", rx_irqs, 1);

        // MSB first, cpol 1, divisor 0
        cfg_msb_first = 1; cfg_cpol = 1; cfg_divisor = 8'd0; tick(2);
        chk(sclk_out == 1'b0, "R9", "clock idles low with cpol 1", sclk_out, 0);
        send(8'h3C, 1, 1); wait_frame();
        chk(last_act_len == 1, "R2", "phase length divisor 0", last_act_len, 1);

        // Divisor 255
        cfg_divisor = 8'd255; cfg_cpol = 0; cfg_msb_first = 0; tick(2);
        send(8'h81, 1, 1); wait_frame();
        chk(last_act_len == 256, "R2", "phase length divisor 255", last_act_len, 256);

        // Back-to-back writes
        cfg_divisor = 8'd3; tick(2);
        send(8'h12, 1, 1); tick(3);
        send(8'hE7, 1, 1);
        chk(!tx_buf_empty, "R13", "second byte held during shift", tx_buf_empty, 0);
        wait_frame(); wait_frame();
        chk(rx_irqs == 5 && tx_buf_empty, "R13", "both bytes delivered", rx_irqs, 5);

        // Transmit interrupt timing
        base_tx = tx_irqs;
        send(8'h5A, 1, 1); wait_frame();
        chk(tx_irqs == base_tx + 1 && txirq_wcnt == 0 && !txirq_trail, "R6",
            "load-time irq before first edge", txirq_wcnt, 0);
        cfg_txirq_done = 1; tick(1);
        send(8'hC6, 1, 1); wait_frame();
        chk(tx_irqs == base_tx + 2 && txirq_wcnt == 7 && txirq_trail, "R6",
            "done-time irq on 8th edge", txirq_wcnt, 7);
        cfg_txirq_done = 0;

        // Inversion
        cfg_invert = 1; tick(1);
        send(8'h1E, 1, 1); wait_frame();
        lb_en = 0; ext_rxd = 1; tick(1);
        base_rx = rx_irqs;
        send(8'hFF, 1, 1); wait_frame();
        chk(rx_irqs == base_rx + 1, "R10", "inverted constant high received", rx_irqs, base_rx + 1);
        lb_en = 1; cfg_invert = 0; tick(1);

        // CTS gating
        cfg_cts_en = 1; cts_n = 1; base_tr = trails;
        send(8'h55, 1, 1); tick(60);
        chk(!tx_buf_empty && trails == base_tr, "R4", "cts high blocks start", trails - base_tr, 0);
        cts_n = 0; wait_frame();
        chk(tx_buf_empty && trails == base_tr + 8, "R4", "cts low releases", trails - base_tr, 8);
        cfg_cts_en = 0; cts_n = 1;

        // Transmitter disabled; receiver alone cannot run
        cfg_tx_en = 0; base_tr = trails; base_rx = rx_irqs;
        send(8'h66, 0, 0); wait_frame();
        chk(!tx_buf_empty && trails == base_tr, "R4", "tx disabled blocks start", trails - base_tr, 0);
        chk(rx_irqs == base_rx, "R5", "no reception without transmitter", rx_irqs, base_rx);
        cfg_rx_en = 0; tick(1);
        txq.push_back(wire_of(8'h66, 0, 0));
        cfg_tx_en = 1; wait_frame();
        chk(rx_irqs == base_rx && trails == base_tr + 8, "R5", "send with rx off gives no rx_irq", rx_irqs, base_rx);
        chk(rts_n, "R12", "rts_n high with receiver off", rts_n, 1);

        // Overrun
        cfg_rx_en = 1; auto_read = 0; tick(1);
        send(8'h11, 1, 1); wait_frame();
        chk(rts_n, "R12", "rts_n high while byte unread", rts_n, 1);
        base_rx = rx_irqs;
        send(8'h22, 0, 1); wait_frame();
        chk(!ovr6 && ovr7, "R8", "overrun raised at 7th bit", {ovr6, ovr7}, 1);
        chk(overrun && rx_irqs == base_rx, "R8", "overrun frame has no rx_irq", rx_irqs, base_rx);
        host_read(); tick(1);
        chk(!overrun && !rts_n, "R8", "read clears overrun", overrun, 0);

        // Continuous receive
        cfg_cont_rx = 1; tick(1);
        base_rx = rx_irqs;
        send(8'h77, 1, 1); wait_frame();
        rxq.push_back(8'h77); txq.push_back(wire_of(8'h77, 0, 0));
        host_read(); wait_frame();
        chk(rx_irqs == base_rx + 2 && tx_buf_empty, "R11", "read re-arms reception", rx_irqs, base_rx + 2);
        cfg_cont_rx = 0; tick(1);
        base_tr = trails;
        host_read(); wait_frame();
        chk(trails == base_tr && rx_irqs == base_rx + 2, "R11", "no re-arm when mode off", trails - base_tr, 0);
        auto_read = 1;

        // External clock
        cfg_ext_clk = 1; sclk_in = 0; tick(4);
        base_rx = rx_irqs;
        send(8'hC3, 1, 0); tick(20);
        chk(!tx_buf_empty, "R3", "start waits for idle clock pin", tx_buf_empty, 0);
        sclk_in = 1; tick(10);
        chk(tx_buf_empty, "R3", "start once pin idles", tx_buf_empty, 1);
        ext_pulses(); tick(10);
        chk(rx_irqs == base_rx + 1, "R3", "byte moved by external clock", rx_irqs, base_rx + 1);
        chk(sclk_out == 1'b1, "R3", "sclk_out idle in external mode", sclk_out, 1);
        cfg_ext_clk = 0; tick(4);

        chk(rxq.size() == 0 && txq.size() == 0, "R7", "scoreboards drained",
            rxq.size() + txq.size(), 0);
        finish_run();
    end

endmodule